// File: doc/BRIEF.md
# Exception Entry Status Update

This block holds a soft processor's status register, its saved-status copy and a small fault-detail register. It rewrites all three in the cycle that the pipeline takes an exception or an interrupt. The surrounding core raises a one-cycle take strobe together with the cause class and, for a memory fault, the fault type. For an external interrupt it also supplies the level, the non-maskable flag and the register-set number requested by the interrupt controller. One clock edge later the status shows the handler's context, and the value that was live before entry sits in the saved copy.

A return strobe brings the whole status back from the saved copy. A software port writes and reads the three registers. Three build-time switches select the optional features: memory management unit, shadow register sets and external interrupt controller. When a feature is left out, the fields that belong to it are held at zero.

The status word is laid out as follows: bit 0 is interrupt enable, bit 1 is user mode, bit 2 is handler active, and bit 3 is the non-maskable flag. Bits [ILW+3:4] hold the interrupt level and bits [ILW+RSW+3:ILW+4] hold the register set, so with the defaults they are [9:4] and [13:10]. In the fault-detail register, bit 0 is double miss, bit 1 is permission violation and bit 2 is bad address. Fault codes are 0 none, 1 TLB miss, 2 permission violation and 3 bad address. A cause value of 1 means external interrupt and 0 means any other exception.

Top module: `excst_top`

## Requirements
- R1: When an exception is taken while handler active (bit 2) is 0, interrupt enable (bit 0) and user mode (bit 1) are 0 on the next cycle.
- R2: When an exception is taken, the saved copy holds the status value from before the exception on the next cycle.
- R3: With the memory management unit built in, handler active (bit 2) is 1 after any taken exception.
- R4: When an exception is taken while handler active is 1, interrupt enable and user mode keep their values.
- R5: Double miss (fault bit 0) is set only when fault code 1 is taken for a non-interrupt cause while handler active was already 1. Every other taken exception clears it.
- R6: Permission violation (fault bit 1) follows fault code 2 and bad address (fault bit 2) follows fault code 3 on a taken non-interrupt exception. An external interrupt clears all three fault bits.
- R7: With the interrupt controller built in, a taken external interrupt loads the level, the non-maskable flag and the register set from the request inputs. A non-interrupt exception leaves those fields unchanged.
- R8: Fields of a feature that is not built in read 0 at all times, including after software writes and taken exceptions. Without the memory management unit the fault bits read 0, and a cause of 1 is handled as a non-interrupt exception when there is no interrupt controller.
- R9: A return strobe without a take copies the saved status into the status register in one cycle.
- R10: Software select 0 writes status, 1 writes the saved copy and 2 writes the fault bits from data [2:0]. Select 3 changes nothing. The read port returns the selected register the same cycle, and 0 for select 3.
- R11: A take strobe overrides a return strobe or a software write in the same cycle. A return strobe overrides a software write.
- R12: After reset, status, saved copy and fault bits are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_take | input | 1 | Take-exception strobe |
| exc_cause | input | 1 | 1 external interrupt, 0 other exception |
| exc_fault | input | 2 | Memory fault code |
| eic_lvl | input | ILW | Requested interrupt level |
| eic_nmi | input | 1 | Requested non-maskable flag |
| eic_rset | input | RSW | Requested register set |
| eret | input | 1 | Return-from-exception strobe |
| wr_en | input | 1 | Software write enable |
| wr_sel | input | 2 | Software write register select |
| wr_data | input | DW | Software write data |
| rd_sel | input | 2 | Software read register select |
| rd_data | output | DW | Software read data |
| status_q | output | DW | Current status |
| saved_q | output | DW | Saved status |
| fault_q | output | 3 | Fault-detail bits |

## Verification
The hardest case to reach is the double miss: a TLB miss has to arrive while a handler is already marked active, and that state comes only from an earlier entry or from a software write. The bench loads every combination of prior handler-active, enable and mode through the software port. It then takes every cause and fault code, first on a build with all features and then on a build with none. A separate sequence of nested entries reaches the same state through real exceptions.

// File: rtl/excst_pkg.sv
package excst_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_MISS = 2'd1,
    FLT_PERM = 2'd2,
    FLT_BAD  = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_SAVED  = 2'd1,
    SEL_FAULT  = 2'd2,
    SEL_NONE   = 2'd3
  } regsel_e;

  localparam int FLT_W = 3;

  // Bits of the status word that exist for a given feature set.
  function automatic logic [63:0] feat_mask(int ilw, int rsw, bit mmu, bit eic, bit sh);
    logic [63:0] m;
    m = 64'h3;
    if (mmu) m[2] = 1'b1;
    if (eic) begin
      m[3] = 1'b1;
      for (int i = 0; i < ilw; i++) m[4+i] = 1'b1;
    end
    if (sh) begin
      for (int i = 0; i < rsw; i++) m[4+ilw+i] = 1'b1;
    end
    return m;
  endfunction

  // Fault-detail bits for a taken exception: {bad, perm, double}.
  function automatic logic [FLT_W-1:0] fault_code(fault_e f, logic ext, logic active_before);
    logic [FLT_W-1:0] r;
    r = '0;
    if (!ext) begin
      r[0] = (f == FLT_MISS) && active_before;
      r[1] = (f == FLT_PERM);
      r[2] = (f == FLT_BAD);
    end
    return r;
  endfunction

endpackage

// File: rtl/excst_entry.sv
module excst_entry
  import excst_pkg::*;
#(
  parameter int ILW        = 6,
  parameter int RSW        = 4,
  parameter bit HAS_MMU    = 1'b1,
  parameter bit HAS_SHADOW = 1'b1,
  parameter bit HAS_EIC    = 1'b1,
  localparam int DW        = 4 + ILW + RSW
) (
  input  logic [DW-1:0]    st_prev,
  input  logic             ext_req,
  input  fault_e           fault,
  input  logic [ILW-1:0]   lvl,
  input  logic             nmi,
  input  logic [RSW-1:0]   rset,
  output logic [DW-1:0]    st_next,
  output logic [FLT_W-1:0] flt_next,
  output logic             ext_eff,
  output logic             nested
);
  localparam int B_IEN = 0;
  localparam int B_UM  = 1;
  localparam int B_HA  = 2;
  localparam int B_NMI = 3;
  localparam int IL_LO = 4;
  localparam int RS_LO = 4 + ILW;
  localparam logic [DW-1:0] MASK = DW'(feat_mask(ILW, RSW, HAS_MMU, HAS_EIC, HAS_SHADOW));

  logic [DW-1:0] nxt;

  assign nested  = HAS_MMU && st_prev[B_HA];
  assign ext_eff = ext_req && HAS_EIC;

  always_comb begin
    nxt = st_prev;
    if (!nested) begin
      nxt[B_IEN] = 1'b0;
      nxt[B_UM]  = 1'b0;
    end
    if (HAS_MMU) nxt[B_HA] = 1'b1;
    if (ext_eff) begin
      nxt[B_NMI]          = nmi;
      nxt[IL_LO +: ILW]   = lvl;
      nxt[RS_LO +: RSW]   = rset;
    end
    st_next = nxt & MASK;
  end

  generate
    if (HAS_MMU) begin : g_flt
      assign flt_next = fault_code(fault, ext_eff, st_prev[B_HA]);
    end else begin : g_noflt
      assign flt_next = '0;
    end
  endgenerate

endmodule

// File: rtl/excst_swport.sv
module excst_swport
  import excst_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic             wr_en,
  input  regsel_e          wr_sel,
  input  logic             blocked,
  input  regsel_e          rd_sel,
  input  logic [DW-1:0]    st_q,
  input  logic [DW-1:0]    sv_q,
  input  logic [FLT_W-1:0] flt_q,
  output logic             wr_st,
  output logic             wr_sv,
  output logic             wr_flt,
  output logic [DW-1:0]    rd_data
);
  assign wr_st  = wr_en && !blocked && (wr_sel == SEL_STATUS);
  assign wr_sv  = wr_en && !blocked && (wr_sel == SEL_SAVED);
  assign wr_flt = wr_en && !blocked && (wr_sel == SEL_FAULT);

  always_comb begin
    case (rd_sel)
      SEL_STATUS: rd_data = st_q;
      SEL_SAVED:  rd_data = sv_q;
      SEL_FAULT:  rd_data = DW'(flt_q);
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/excst_top.sv
module excst_top
  import excst_pkg::*;
#(
  parameter int ILW        = 6,
  parameter int RSW        = 4,
  parameter bit HAS_MMU    = 1'b1,
  parameter bit HAS_SHADOW = 1'b1,
  parameter bit HAS_EIC    = 1'b1,
  localparam int DW        = 4 + ILW + RSW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_take,
  input  logic             exc_cause,
  input  logic [1:0]       exc_fault,
  input  logic [ILW-1:0]   eic_lvl,
  input  logic             eic_nmi,
  input  logic [RSW-1:0]   eic_rset,
  input  logic             eret,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [1:0]       rd_sel,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    status_q,
  output logic [DW-1:0]    saved_q,
  output logic [FLT_W-1:0] fault_q
);
  localparam int B_HA = 2;
  localparam logic [DW-1:0] MASK = DW'(feat_mask(ILW, RSW, HAS_MMU, HAS_EIC, HAS_SHADOW));

  logic [DW-1:0]    st_next;
  logic [FLT_W-1:0] flt_next;
  logic             ext_eff, nested;
  logic             wr_st, wr_sv, wr_flt;
  logic             do_ret;

  excst_entry #(
    .ILW(ILW), .RSW(RSW), .HAS_MMU(HAS_MMU), .HAS_SHADOW(HAS_SHADOW), .HAS_EIC(HAS_EIC)
  ) u_entry (
    .st_prev (status_q),
    .ext_req (exc_cause),
    .fault   (fault_e'(exc_fault)),
    .lvl     (eic_lvl),
    .nmi     (eic_nmi),
    .rset    (eic_rset),
    .st_next (st_next),
    .flt_next(flt_next),
    .ext_eff (ext_eff),
    .nested  (nested)
  );

  assign do_ret = eret && !exc_take;

  excst_swport #(.DW(DW)) u_sw (
    .wr_en  (wr_en),
    .wr_sel (regsel_e'(wr_sel)),
    .blocked(exc_take || eret),
    .rd_sel (regsel_e'(rd_sel)),
    .st_q   (status_q),
    .sv_q   (saved_q),
    .flt_q  (fault_q),
    .wr_st  (wr_st),
    .wr_sv  (wr_sv),
    .wr_flt (wr_flt),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      saved_q  <= '0;
    end else if (exc_take) begin
      status_q <= st_next;
      saved_q  <= status_q;
    end else if (do_ret) begin
      status_q <= saved_q;
    end else begin
      if (wr_st) status_q <= wr_data & MASK;
      if (wr_sv) saved_q  <= wr_data & MASK;
    end
  end

  generate
    if (HAS_MMU) begin : g_fltreg
      always_ff @(posedge clk) begin
        if (!rst_n)        fault_q <= '0;
        else if (exc_take) fault_q <= flt_next;
        else if (wr_flt)   fault_q <= wr_data[FLT_W-1:0];
      end
    end else begin : g_fltzero
      assign fault_q = '0;
    end
  endgenerate

  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && !status_q[B_HA] |=> status_q[1:0] == 2'b00); // R1
  AST_SAVE_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> saved_q == $past(status_q)); // R2
  AST_HANDLER_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && HAS_MMU |=> status_q[B_HA]); // R3
  AST_NESTED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && nested |=> status_q[1:0] == $past(status_q[1:0])); // R4
  AST_NO_DOUBLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && !nested |=> !fault_q[0]); // R5
  AST_EXT_CLEARS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && ext_eff |=> fault_q == '0); // R6
  AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q | saved_q) & ~MASK) == '0); // R8
  AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    do_ret |=> status_q == $past(saved_q)); // R9
  AST_TAKE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && wr_en |=> fault_q == $past(flt_next) && status_q == $past(st_next)); // R11

endmodule

// File: tb/sim_excst_top.sv
module sim_excst_top;
  localparam int ILW = 6;
  localparam int RSW = 4;
  localparam int DW  = 14;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, take, cause, nmi, eret, wr_en;
  logic [1:0]    fault, wr_sel, rd_sel;
  logic [ILW-1:0] lvl;
  logic [RSW-1:0] rs;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd0, st0, sv0, rd1, st1, sv1;
  logic [2:0]    fl0, fl1;

  int checks = 0;
  int errors = 0;

  excst_top u0 (
    .clk(clk), .rst_n(rst_n), .exc_take(take), .exc_cause(cause), .exc_fault(fault),
    .eic_lvl(lvl), .eic_nmi(nmi), .eic_rset(rs), .eret(eret), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd0),
    .status_q(st0), .saved_q(sv0), .fault_q(fl0));

  excst_top #(.HAS_MMU(1'b0), .HAS_SHADOW(1'b0), .HAS_EIC(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .exc_take(take), .exc_cause(cause), .exc_fault(fault),
    .eic_lvl(lvl), .eic_nmi(nmi), .eic_rset(rs), .eret(eret), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd1),
    .status_q(st1), .saved_q(sv1), .fault_q(fl1));

  logic [DW-1:0] m_st [2];
  logic [DW-1:0] m_sv [2];
  logic [2:0]    m_fl [2];

  function automatic logic [DW-1:0] fmask(int c);
    return (c == 0) ? 14'h3fff : 14'h0003;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    take = 0; cause = 0; fault = 0; lvl = 0; nmi = 0; rs = 0;
    eret = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
  endtask

  // Advance the reference by one edge, clock, then compare both builds.
  task automatic tick(string ts, string tf);
    for (int c = 0; c < 2; c++) begin
      logic mmu, ext;
      logic [DW-1:0] ns;
      mmu = (c == 0);
      ext = cause && (c == 0);
      if (take) begin
        ns = m_st[c];
        if (!(mmu && m_st[c][2])) ns[1:0] = 2'b00;
        if (mmu) ns[2] = 1'b1;
        if (ext) begin ns[3] = nmi; ns[9:4] = lvl; ns[13:10] = rs; end
        m_fl[c] = (mmu && !ext) ? {fault == 2'd3, fault == 2'd2, (fault == 2'd1) && m_st[c][2]} : 3'b0;
        m_sv[c] = m_st[c];
        m_st[c] = ns & fmask(c);
      end else if (eret) begin
        m_st[c] = m_sv[c];
      end else if (wr_en) begin
        if (wr_sel == 2'd0) m_st[c] = wr_data & fmask(c);
        if (wr_sel == 2'd1) m_sv[c] = wr_data & fmask(c);
        if (wr_sel == 2'd2) m_fl[c] = mmu ? wr_data[2:0] : 3'b0;
      end
    end
    @(posedge clk); #1;
    idle();
    check(ts, st0, m_st[0]); check(ts, st1, m_st[1]);
    check("R2", sv0, m_sv[0]); check("R2", sv1, m_sv[1]);
    check(tf, DW'(fl0), DW'(m_fl[0])); check(tf, DW'(fl1), DW'(m_fl[1]));
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(); rd_sel = 0; rst_n = 0;
    for (int c = 0; c < 2; c++) begin m_st[c] = 0; m_sv[c] = 0; m_fl[c] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R12 reset state
    check("R12", st0, 0); check("R12", sv0, 0); check("R12", DW'(fl0), 0);
    check("R12", st1, 0); check("R12", sv1, 0);

    // Sweep prior handler/enable/mode against every cause and fault code.
    for (int hp = 0; hp < 2; hp++)
      for (int iu = 0; iu < 4; iu++)
        for (int cs = 0; cs < 2; cs++)
          for (int f = 0; f < 4; f++) begin
            wr_en = 1; wr_sel = 0;
            wr_data = {4'(f + 5), 6'(iu * 9 + f), 1'(cs), 1'(hp), 2'(iu)};
            tick("R10", "R10");
            take = 1; cause = 1'(cs); fault = 2'(f);
            lvl = 6'(17 + f * 11 + iu); nmi = 1'(f & 1); rs = 4'(15 - f - iu);
            tick(hp ? "R4" : (cs ? "R7" : "R1"), (f == 1) ? "R5" : "R6");
            check("R3", DW'(st0[2]), 1);
            check("R8", st1 & ~14'h3, 0);
            check("R8", DW'(fl1), 0);
          end

    // Nested entries reach a double miss through real exceptions.
    idle(); wr_en = 1; wr_sel = 2'd0; wr_data = 14'h0003; tick("R10", "R10");
    take = 1; fault = 2'd1; tick("R1", "R5");
    check("R5", DW'(fl0), 0);
    take = 1; fault = 2'd1; tick("R4", "R5");
    check("R5", DW'(fl0), 1);
    take = 1; cause = 1; fault = 2'd1; lvl = 6'h2a; nmi = 1; rs = 4'h9; tick("R7", "R6");

    // Return restores from the saved copy.
    wr_en = 1; wr_sel = 2'd1; wr_data = 14'h2aa7; tick("R10", "R10");
    eret = 1; tick("R9", "R9");
    check("R9", st0, 14'h2aa7); check("R9", st1, 14'h0003);

    // Software port: each register, select 3 ignored, readback.
    wr_en = 1; wr_sel = 2'd2; wr_data = 14'h0005; tick("R10", "R10");
    wr_en = 1; wr_sel = 2'd3; wr_data = 14'h3fff; tick("R10", "R10");
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s); #1;
      check("R10", rd0, s == 0 ? m_st[0] : s == 1 ? m_sv[0] : s == 2 ? DW'(m_fl[0]) : 0);
      check("R10", rd1, s == 0 ? m_st[1] : s == 1 ? m_sv[1] : 0);
    end

    // Priority: take over return and writes, return over writes.
    take = 1; eret = 1; wr_en = 1; wr_sel = 2'd2; wr_data = 14'h0007; fault = 2'd2;
    tick("R11", "R11");
    take = 1; wr_en = 1; wr_sel = 2'd0; wr_data = 14'h1234; tick("R11", "R11");
    eret = 1; wr_en = 1; wr_sel = 2'd0; wr_data = 14'h0001; tick("R11", "R11");
    eret = 1; wr_en = 1; wr_sel = 2'd1; wr_data = 14'h0002; tick("R11", "R11");

    // Absent features after writes of all ones.
    wr_en = 1; wr_sel = 2'd0; wr_data = 14'h3fff; tick("R8", "R8");
    check("R8", st1, 14'h0003);

    // Reset again clears everything.
    rst_n = 0; @(posedge clk); #1; rst_n = 1;
    for (int c = 0; c < 2; c++) begin m_st[c] = 0; m_sv[c] = 0; m_fl[c] = 0; end
    check("R12", st0, 0); check("R12", sv0, 0); check("R12", DW'(fl0), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule